// File: doc/BRIEF.md
# Inter-Processor Interrupt Generator

This block lets any master on a simple 32-bit register bus signal one of three processor cores. Each core has a generation register and an acknowledge register. Writing the generation register sets sticky source flags that tell the core who is calling, and can fire a one-cycle interrupt pulse toward that core. The core, or anyone else, then writes the acknowledge register to clear the flags it has handled.

There are 28 source flags per core. They sit in bits 31:4 of both registers of a pair, and both registers read back the same stored value. Bit 0 of a generation register is a trigger. It stores nothing, so it always reads as zero. Bits 3:1 are reserved. The bus has no byte enables, no handshake and no wait states. A write takes effect on the clock edge where `bus_we` is high. Read data follows `bus_addr` combinationally.

Top module: `ipi_gen_top`

## Requirements
- R1: After synchronous reset, every source flag is 0, every register reads 0, and `irq_pulse` is all zero.
- R2: A write to generation register n sets flag k of core n for every bit k+4 of the write data that is 1. Flags whose data bit is 0 keep their value, so successive writes accumulate.
- R3: A write to acknowledge register n clears flag k of core n for every data bit k+4 that is 1. Flags whose data bit is 0 keep their value.
- R4: A write with bit 0 set to generation register n drives `irq_pulse[n]` high for exactly one cycle, in the cycle right after the write edge. A write with bit 0 clear gives no pulse. Trigger writes on consecutive cycles give pulses on consecutive cycles.
- R5: Generation register n and acknowledge register n both read `{flags_n, 4'b0000}`.
- R6: Bits 3:1 of written data are ignored, and read data bits 3:0 are always 0.
- R7: The map is as follows. Generation registers are at byte offsets 0x00, 0x04 and 0x08, for n = 0, 1, 2. Acknowledge registers are at 0x10, 0x14 and 0x18. Every other offset reads 0 and ignores writes, including offsets not aligned to a word, 0x0C, 0x1C and 0x20 and above.
- R8: A write affects only the core whose register is addressed. Bit 0 of an acknowledge register fires no pulse, and at most one `irq_pulse` bit is high in any cycle.
- R9: A single generation write can set flags and fire the trigger together. The pulse fires whether or not the flags were already set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_we | input | 1 | Write strobe; the write takes effect on this clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_pulse | output | 3 | One-cycle interrupt pulse per target core |

## Verification
Read data depends on the address with no register in between, so a read is checked in the same cycle its address is presented. After a write edge, the new flag values can be read back in the very next cycle. The pulse for a write appears in the cycle after that edge, so the scoreboard queues the expected pulse vector for that cycle and an all-zero vector for the cycle after it. The monitor samples on the falling clock edge, away from the edge where inputs change and state updates.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

    localparam int TGT_CNT   = 3;
    localparam int DATA_W    = 32;
    localparam int SRC_LSB   = 4;
    localparam int SRC_W     = DATA_W - SRC_LSB;
    localparam int ADDR_W    = 8;
    localparam int IDX_W     = 2;
    localparam int TRIG_BIT  = 0;
    localparam int KIND_BIT  = 4;
    localparam int MAP_TOP   = 5;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_GEN  = 2'd1,
        SEL_ACK  = 2'd2
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e        kind;
        logic [IDX_W-1:0] idx;
    } reg_sel_t;

    typedef struct packed {
        logic [SRC_W-1:0] src;
        logic             trig;
    } wr_word_t;

    function automatic logic [DATA_W-1:0] readback(input logic [SRC_W-1:0] f);
        return {f, {SRC_LSB{1'b0}}};
    endfunction

endpackage

// File: rtl/ipi_decode.sv
module ipi_decode
    import ipi_pkg::*;
#(
    parameter int A_W   = ADDR_W,
    parameter int N_TGT = TGT_CNT
) (
    input  logic [A_W-1:0] addr,
    output reg_sel_t       sel
);

    logic [IDX_W-1:0] word_idx;
    logic             upper_zero;
    logic             aligned;

    assign word_idx   = addr[IDX_W+1:2];
    assign upper_zero = (addr[A_W-1:MAP_TOP] == '0);
    assign aligned    = (addr[1:0] == 2'b00);

    always_comb begin
        sel.kind = SEL_NONE;
        sel.idx  = '0;
        if (aligned && upper_zero && (int'(word_idx) < N_TGT)) begin
            sel.kind = addr[KIND_BIT] ? SEL_ACK : SEL_GEN;
            sel.idx  = word_idx;
        end
    end

endmodule

// File: rtl/ipi_slot.sv
module ipi_slot
    import ipi_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  reg_sel_t         sel,
    input  wr_word_t         wword,
    output logic [SRC_W-1:0] flags_o,
    output logic             irq_o
);

    logic             hit;
    logic             gen_hit;
    logic             ack_hit;
    logic [SRC_W-1:0] set_mask;
    logic [SRC_W-1:0] clr_mask;

    assign hit      = wr_en && (sel.idx == IDX_W'(IDX));
    assign gen_hit  = hit && (sel.kind == SEL_GEN);
    assign ack_hit  = hit && (sel.kind == SEL_ACK);
    assign set_mask = gen_hit ? wword.src : '0;
    assign clr_mask = ack_hit ? wword.src : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_o <= '0;
            irq_o   <= 1'b0;
        end else begin
            flags_o <= (flags_o | set_mask) & ~clr_mask;
            irq_o   <= gen_hit && wword.trig;
        end
    end

    assert_set_needs_gen_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(gen_hit) |-> ((flags_o & ~$past(flags_o)) == '0));

    assert_clear_needs_ack_R3: assert property (@(posedge clk) disable iff (rst)
        !$past(ack_hit) |-> (($past(flags_o) & ~flags_o) == '0));

    assert_pulse_needs_trigger_R4: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> ($past(wr_en) && $past(wword.trig)));

    assert_pulse_only_from_gen_R8: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> ($past(sel.kind) == SEL_GEN));

endmodule

// File: rtl/ipi_rdmux.sv
module ipi_rdmux
    import ipi_pkg::*;
#(
    parameter int N_TGT = TGT_CNT
) (
    input  reg_sel_t                    sel,
    input  logic [N_TGT-1:0][SRC_W-1:0] flags,
    output logic [DATA_W-1:0]           rdata
);

    always_comb begin
        rdata = '0;
        for (int i = 0; i < N_TGT; i++) begin
            if ((sel.kind != SEL_NONE) && (int'(sel.idx) == i)) begin
                rdata = readback(flags[i]);
            end
        end
    end

endmodule

// File: rtl/ipi_gen_top.sv
module ipi_gen_top
    import ipi_pkg::*;
#(
    parameter int N_TGT = TGT_CNT,
    parameter int A_W   = ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [A_W-1:0]    bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [N_TGT-1:0]  irq_pulse
);

    reg_sel_t                    sel;
    wr_word_t                    wword;
    logic [N_TGT-1:0][SRC_W-1:0] flags;
    logic                        unused_rsvd;

    assign wword.src   = bus_wdata[DATA_W-1:SRC_LSB];
    assign wword.trig  = bus_wdata[TRIG_BIT];
    assign unused_rsvd = ^bus_wdata[SRC_LSB-1:TRIG_BIT+1];

    ipi_decode #(.A_W(A_W), .N_TGT(N_TGT)) u_decode (
        .addr (bus_addr),
        .sel  (sel)
    );

    for (genvar g = 0; g < N_TGT; g++) begin : g_slot
        ipi_slot #(.IDX(g)) u_slot (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (bus_we),
            .sel     (sel),
            .wword   (wword),
            .flags_o (flags[g]),
            .irq_o   (irq_pulse[g])
        );
    end

    ipi_rdmux #(.N_TGT(N_TGT)) u_rdmux (
        .sel   (sel),
        .flags (flags),
        .rdata (bus_rdata)
    );

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> ((irq_pulse == '0) && (flags == '0)));

    assert_low_nibble_zero_R6: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[SRC_LSB-1:0] == '0);

    assert_unmapped_reads_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (sel.kind == SEL_NONE) |-> (bus_rdata == '0));

    assert_single_target_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(irq_pulse));

endmodule

// File: tb/test_ipi_gen_top.sv
module test_ipi_gen_top;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  irq_pulse;

    item_t       q[$];
    logic        chk_en = 1'b0;
    int          checks = 0;
    int          failures = 0;
    logic [27:0] model [3];

    always #10 clk = ~clk;

    ipi_gen_top i_ipi_gen_top (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_pulse (irq_pulse)
    );

    // bench decode of the map: kind 0 none, 1 gen, 2 ack
    function automatic int kind_of(input logic [7:0] a);
        if (a[1:0] != 2'b00 || a[7:5] != 3'b000 || a[3:2] == 2'd3) return 0;
        return a[4] ? 2 : 1;
    endfunction

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        if (kind_of(a) == 0) return 32'h0;
        return {model[a[3:2]], 4'h0};
    endfunction

    always @(negedge clk) begin
        if (chk_en) begin
            if (q.size() == 0) begin
                failures++;
                $display("FAIL scoreboard empty actual=none expected=item");
            end else begin
                item_t it;
                logic [31:0] act;
                it  = q.pop_front();
                act = it.is_irq ? {29'b0, irq_pulse} : bus_rdata;
                checks++;
                if (act !== it.exp) begin
                    failures++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic push(input bit is_irq, input logic [31:0] e, input string tag);
        item_t it;
        it.is_irq = is_irq;
        it.exp    = e;
        it.tag    = tag;
        q.push_back(it);
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        bus_addr = a;
        push(1'b0, exp_read(a), tag);
        chk_en = 1'b1;
        @(posedge clk);
        #1 chk_en = 1'b0;
    endtask

    task automatic model_wr(input logic [7:0] a, input logic [31:0] d, output logic [2:0] p);
        int k;
        k = kind_of(a);
        p = 3'b000;
        if (k == 1) begin
            model[a[3:2]] = model[a[3:2]] | d[31:4];
            if (d[0]) p[a[3:2]] = 1'b1;
        end else if (k == 2) begin
            model[a[3:2]] = model[a[3:2]] & ~d[31:4];
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
        logic [2:0] p;
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(posedge clk);
        #1 bus_we = 1'b0;
        model_wr(a, d, p);
        push(1'b1, {29'b0, p}, {tag, " pulse"});
        chk_en = 1'b1;
        @(posedge clk);
        #1 push(1'b1, 32'h0, {tag, " pulse end"});
        @(posedge clk);
        #1 chk_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [2:0] p;
        for (int i = 0; i < 3; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        push(1'b1, 32'h0, "R1 irq after reset");
        chk_en = 1'b1;
        @(posedge clk);
        #1 chk_en = 1'b0;
        rd(8'h00, "R1 gen0 reset"); rd(8'h04, "R1 gen1 reset"); rd(8'h08, "R1 gen2 reset");
        rd(8'h10, "R1 ack0 reset"); rd(8'h14, "R1 ack1 reset"); rd(8'h18, "R1 ack2 reset");

        // R2, R4 (no trigger), R5
        wr(8'h00, 32'h0000_00F0, "R4 no trigger");
        rd(8'h00, "R2 gen0 set");
        rd(8'h10, "R5 ack0 mirrors gen0");
        wr(8'h00, 32'h0000_0100, "R2 accumulate");
        rd(8'h00, "R2 gen0 accumulated");
        wr(8'h00, 32'h0000_0000, "R2 zero write");
        rd(8'h00, "R2 zero write keeps flags");

        // R6: reserved bits ignored
        wr(8'h00, 32'h0000_000E, "R6 reserved write");
        rd(8'h00, "R6 reserved bits ignored");

        // R4 and R8: trigger core 1 only
        wr(8'h04, 32'h0000_0001, "R4 trigger core1");
        rd(8'h04, "R4 trigger stores nothing");
        rd(8'h00, "R8 core0 untouched");

        // R9: combined set and trigger
        wr(8'h08, 32'hF000_0011, "R9 combined core2");
        rd(8'h08, "R9 combined flags");
        wr(8'h08, 32'hF000_0011, "R9 pulse with flags already set");
        rd(8'h18, "R5 ack2 mirrors gen2");

        // R3: acknowledge clears
        wr(8'h10, 32'h0000_0030, "R3 ack0 clear");
        rd(8'h00, "R3 gen0 after clear");
        wr(8'h10, 32'h0000_0000, "R3 ack zero write");
        rd(8'h10, "R3 ack zero keeps flags");
        wr(8'h18, 32'h8000_0000, "R3 ack2 clear top flag");
        rd(8'h08, "R3 gen2 top flag cleared");

        // R8: ack trigger bit does not pulse
        wr(8'h14, 32'h0000_0001, "R8 ack bit0 no pulse");

        // R7: unmapped offsets
        wr(8'h0C, 32'hFFFF_FFF1, "R7 write 0x0C ignored");
        wr(8'h1C, 32'hFFFF_FFF1, "R7 write 0x1C ignored");
        wr(8'h20, 32'hFFFF_FFF1, "R7 write 0x20 ignored");
        wr(8'h02, 32'hFFFF_FFF1, "R7 write unaligned ignored");
        rd(8'h0C, "R7 read 0x0C"); rd(8'h1C, "R7 read 0x1C");
        rd(8'h20, "R7 read 0x20"); rd(8'h01, "R7 read unaligned");
        rd(8'h00, "R7 gen0 unchanged"); rd(8'h04, "R7 gen1 unchanged");
        rd(8'h08, "R7 gen2 unchanged");

        // R4: back-to-back triggers
        bus_addr  = 8'h04;
        bus_wdata = 32'h0000_0001;
        bus_we    = 1'b1;
        @(posedge clk);
        #1 model_wr(8'h04, 32'h1, p);
        push(1'b1, 32'h2, "R4 back-to-back first");
        chk_en = 1'b1;
        @(posedge clk);
        #1 bus_we = 1'b0;
        push(1'b1, 32'h2, "R4 back-to-back second");
        @(posedge clk);
        #1 push(1'b1, 32'h0, "R4 back-to-back end");
        @(posedge clk);
        #1 chk_en = 1'b0;

        if (q.size() != 0) begin
            failures++;
            $display("FAIL scoreboard leftover actual=%0d expected=0", q.size());
        end
        finish_run();
    end

endmodule